// File: doc/BRIEF.md
# Array Multiply-Accumulate Unit

This block forms the sum of a product and an addend, P = X·Y + K, from two N-bit factors and one N-bit addend. The result is 2N bits wide. It is built only from logic gates and a grid of full adders, with no clock and no storage, so P follows its inputs after the array's propagation delay. A parent design places registers around it as its timing needs.

Each bit of Y selects a copy of X, shifted left by that bit's position. That copy is called a partial product. The partial products are summed by N rows of ripple adders into an accumulator, and the accumulator starts at the extended addend. A mode pin chooses between unsigned and two's-complement operation.

In signed mode, X and K are sign-extended to the full 2N bits. The row selected by the top bit of Y carries negative weight, so that row is subtracted through adder cells that can add or subtract. Fixed-point factors need no extra hardware: the number of fractional bits in P is the sum of those in X and Y.

Top module: `mac_array`

## Requirements
- R1: With `signed_i` = 0, `p_o` equals X·Y + K for X, Y and K read as unsigned values, over the full 2N-bit width with no wrap-around.
- R2: In unsigned mode with K = 0, X = 4'b1011 and Y = 4'b1110 give `p_o` = 8'b10011010 (154).
- R3: With `signed_i` = 1, X, Y and K are read as two's complement. `p_o` is the two's-complement encoding of X·Y + K in 2N bits, with K sign-extended.
- R4: In signed mode with K = 0, X = 4'b1001 (−7) and Y = 4'b1101 (−3) give `p_o` = 8'b00010101 (+21).
- R5: The mode pin encoding is 0 for unsigned and 1 for signed. With X = Y = 4'b1111 and K = 0, `p_o` is 8'hE1 in unsigned mode and 8'h01 in signed mode.
- R6: When Y = 0 or X = 0, `p_o` equals K extended to 2N bits: zero-extended in unsigned mode and sign-extended in signed mode.
- R7: When Y = 1, `p_o` equals X + K, both extended to 2N bits according to the mode.
- R8: The signed extremes are exact. X = Y = −8 with K = 7 gives 71 (8'h47). X = −8, Y = 7 with K = −8 gives −64 (8'hC0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Multiplicand X |
| y_i | input | N | Multiplier Y; each of its bits enables one row of the array |
| k_i | input | N | Addend K |
| signed_i | input | 1 | 0 = unsigned, 1 = two's complement |
| p_o | output | 2N | Result X·Y + K |

## Verification
Two signed-mode effects can act on the same input vector. One is the sign extension of a negative addend. The other is the subtraction of the row selected by Y's top bit. Both meet in the top bits of the accumulator, and carries must cancel there correctly.

The exhaustive sweep drives every X, Y and K in both modes. It therefore applies every vector with K < 0 and Y's top bit set, including the −8 extremes. Each result is compared with a reference built on integer arithmetic at the falling clock edge after the inputs were applied.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MAC_UNSIGNED = 1'b0,
    MAC_SIGNED   = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_fa_cell.sv
// Full adder whose b input is inverted when sub_i is set (add/subtract cell).
module mac_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic sub_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic b_eff;
  assign b_eff = b_i ^ sub_i;
  assign s_o   = a_i ^ b_eff ^ c_i;
  assign c_o   = (a_i & b_eff) | (a_i & c_i) | (b_eff & c_i);
endmodule

// File: rtl/mac_pp_row.sv
// One partial-product row: X (optionally sign-extended) gated by one Y bit, shifted.
module mac_pp_row #(
  parameter int N     = 4,
  parameter int SHIFT = 0
) (
  input  logic [N-1:0]   x_i,
  input  logic           ybit_i,
  input  logic           sext_i,
  output logic [2*N-1:0] row_o
);
  localparam int PW = 2 * N;
  logic [PW-1:0] x_ext;
  assign x_ext = {{N{x_i[N-1] & sext_i}}, x_i};
  assign row_o = (x_ext & {PW{ybit_i}}) << SHIFT;
endmodule

// File: rtl/mac_adder_row.sv
// Ripple row of add/subtract cells across the full result width.
module mac_adder_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] row_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;
  assign carry[0] = sub_i;

  for (genvar b = 0; b < W; b++) begin : g_cell
    mac_fa_cell u_fa (
      .a_i  (acc_i[b]),
      .b_i  (row_i[b]),
      .sub_i(sub_i),
      .c_i  (carry[b]),
      .s_o  (sum_o[b]),
      .c_o  (carry[b+1])
    );
  end

  logic unused_carry;
  assign unused_carry = carry[W];
endmodule

// File: rtl/mac_array.sv
module mac_array
  import mac_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  input  logic [N-1:0]   k_i,
  input  logic           signed_i,
  output logic [2*N-1:0] p_o
);
  localparam int PW = 2 * N;

  mac_mode_e mode;
  assign mode = mac_mode_e'(signed_i);

  logic sext;
  assign sext = (mode == MAC_SIGNED);

  logic [PW-1:0] acc [0:N];
  assign acc[0] = {{N{k_i[N-1] & sext}}, k_i};

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [PW-1:0] row;
    logic          sub;

    mac_pp_row #(.N(N), .SHIFT(i)) u_pp (
      .x_i   (x_i),
      .ybit_i(y_i[i]),
      .sext_i(sext),
      .row_o (row)
    );

    if (i == N - 1) begin : g_top
      assign sub = sext;
    end else begin : g_mid
      assign sub = 1'b0;
    end

    mac_adder_row #(.W(PW)) u_add (
      .acc_i(acc[i]),
      .row_i(row),
      .sub_i(sub),
      .sum_o(acc[i+1])
    );
  end

  assign p_o = acc[N];
endmodule

// File: rtl/mac_array_chk.sv
module mac_array_chk #(
  parameter int N = 4
) (
  input logic [N-1:0]   x_i,
  input logic [N-1:0]   y_i,
  input logic [N-1:0]   k_i,
  input logic           signed_i,
  input logic [2*N-1:0] p_o
);
  localparam int PW = 2 * N;
  logic [PW-1:0] k_ext, x_ext;
  assign k_ext = signed_i ? {{N{k_i[N-1]}}, k_i} : {{N{1'b0}}, k_i};
  assign x_ext = signed_i ? {{N{x_i[N-1]}}, x_i} : {{N{1'b0}}, x_i};

  always_comb begin
    if (y_i == '0 || x_i == '0) begin
      a_r6_zero_factor: assert (p_o == k_ext) else $error("R6 zero factor");
    end
    if (y_i == N'(1)) begin
      a_r7_unit_factor: assert (p_o == PW'(x_ext + k_ext)) else $error("R7 unit factor");
    end
    if (!signed_i) begin
      a_r1_no_wrap: assert (p_o >= k_ext) else $error("R1 wrapped");
    end
    if (signed_i && x_i == {1'b1, {(N-1){1'b0}}} && y_i == {1'b1, {(N-1){1'b0}}}) begin
      a_r8_min_square: assert (p_o == PW'(k_ext + (PW'(1) << (PW-2)))) else $error("R8 min square");
    end
  end
endmodule

bind mac_array mac_array_chk #(.N(N)) u_chk (
  .x_i(x_i), .y_i(y_i), .k_i(k_i), .signed_i(signed_i), .p_o(p_o)
);

// File: tb/sim_mac_array.sv
module sim_mac_array;
  localparam int N = 4;
  localparam int PW = 2 * N;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]  x, y, k;
  logic          sgn;
  logic [PW-1:0] p;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mac_array #(.N(N)) u0 (.x_i(x), .y_i(y), .k_i(k), .signed_i(sgn), .p_o(p));

  function automatic int as_int(input logic [N-1:0] v, input logic s);
    int r;
    r = int'(v);
    if (s && v[N-1]) r = r - (1 << N);
    return r;
  endfunction

  function automatic logic [PW-1:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                          input logic [N-1:0] c, input logic s);
    int r;
    r = as_int(a, s) * as_int(b, s) + as_int(c, s);
    return PW'(r);
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] exp);
    checks++;
    if (p !== exp) begin
      fails++;
      $display("FAIL %s x=%h y=%h k=%h s=%0b got %h exp %h", tag, x, y, k, sgn, p, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [N-1:0] c, input logic s);
    @(posedge clk);
    x = a; y = b; k = c; sgn = s;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    x = '0; y = '0; k = '0; sgn = 1'b0;
    @(negedge clk);
    check("R6 idle zero", 8'h00);

    apply(4'b1011, 4'b1110, 4'h0, 1'b0); check("R2 11x14", 8'b10011010);
    apply(4'b1001, 4'b1101, 4'h0, 1'b1); check("R4 -7x-3", 8'b00010101);
    apply(4'hF, 4'hF, 4'h0, 1'b0);       check("R5 unsigned 15x15", 8'hE1);
    apply(4'hF, 4'hF, 4'h0, 1'b1);       check("R5 signed -1x-1", 8'h01);
    apply(4'h5, 4'h0, 4'hA, 1'b1);       check("R6 signed y0", 8'hFA);
    apply(4'h0, 4'h9, 4'hA, 1'b0);       check("R6 unsigned x0", 8'h0A);
    apply(4'hC, 4'h1, 4'hE, 1'b1);       check("R7 signed y1", 8'hFA);
    apply(4'hC, 4'h1, 4'hE, 1'b0);       check("R7 unsigned y1", 8'h1A);
    apply(4'h8, 4'h8, 4'h7, 1'b1);       check("R8 -8x-8+7", 8'h47);
    apply(4'h8, 4'h7, 4'h8, 1'b1);       check("R8 -8x7-8", 8'hC0);
    apply(4'hF, 4'hF, 4'hF, 1'b0);       check("R1 max", 8'hF0);

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << N); a++) begin
        for (int b = 0; b < (1 << N); b++) begin
          for (int c = 0; c < (1 << N); c++) begin
            apply(N'(a), N'(b), N'(c), m[0]);
            check(m == 0 ? "R1 sweep" : "R3 sweep", model(N'(a), N'(b), N'(c), m[0]));
          end
        end
      end
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule